// File: doc/BRIEF.md
# Cell Undervoltage/Overvoltage Hysteresis Comparator

This block sits behind a measurement sequencer in a battery stack monitor. Each time the sequencer presents a digitised reading (in millivolts) with its channel index and a valid strobe, the block compares it against the thresholds picked by the configuration selects. It then updates a latched fault flag for that channel.

Cell channels have both an undervoltage and an overvoltage check. Each check has its own programmable hysteresis band, so a flag that has set needs the reading to move well past the trip point before it clears. The temperature channels have only an undervoltage check, at half the supplied reference value.

A single stack-good output summarises the stack. It is refreshed once per measurement pass, when the final temperature channel's reading arrives. Cells above the configured cell count do not affect it.

Top module: `cell_fault_comparator`

## Requirements
- R1: Every three-level select is a 2-bit code: 2'b10 is the high level (digit 0), 2'b01 is mid (digit 1), 2'b00 is low (digit 2), and 2'b11 is read as high. A pair of selects forms a table index of 3*upper_digit + lower_digit.
- R2: The overvoltage threshold by index 0..8 is 4498, 4403, 4307, 4211, 4116, 4020, 3924, 3828, 3733 mV. A clear cell OV flag sets when the reading is strictly above the threshold.
- R3: The undervoltage threshold by index 0..8 is 2871, 2680, 2489, 2297, 2106, 1914, 1723, 1531, 766 mV. A clear cell UV flag sets when the reading is strictly below the threshold.
- R4: The hysteresis select gives UV/OV bands of 500/200 mV at the high level, 250/100 mV at mid and 0/0 mV at low. A set UV flag clears only when the reading is above threshold plus the UV band. A set OV flag clears only when the reading is below threshold minus the OV band. Otherwise the flag holds.
- R5: When undervoltage index 8 (766 mV) is selected, the UV band is zero whatever the hysteresis select says.
- R6: Channels NCELL..NCELL+NTEMP-1 are temperature channels. They use a UV threshold of floor(vref_mv/2), with no hysteresis and no OV check.
- R7: The cell count is 12 minus the cell-count index. Cells with an index at or above that count are left out of stack-good, although their flags still follow their readings. Temperature channels are always included.
- R8: stack_good changes only on the clock edge that accepts a valid reading on the last channel (NCELL+NTEMP-1). At that edge it becomes high exactly when no included flag is set, counting the result of that last reading.
- R9: A flag changes only on the edge that accepts a valid reading for its own channel. A reading with a channel index of NCELL+NTEMP or more has no effect.
- R10: Reset clears every flag and sets stack_good high.
- R11: A cell channel never has its UV and OV flags set at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Reading strobe |
| rd_chan | input | CHW | Channel index of the reading |
| rd_mv | input | MVW | Reading in millivolts |
| ov_hi_sel | input | 2 | Overvoltage select, upper digit |
| ov_lo_sel | input | 2 | Overvoltage select, lower digit |
| uv_hi_sel | input | 2 | Undervoltage select, upper digit |
| uv_lo_sel | input | 2 | Undervoltage select, lower digit |
| hyst_sel | input | 2 | Hysteresis select |
| cc_hi_sel | input | 2 | Cell-count select, upper digit |
| cc_lo_sel | input | 2 | Cell-count select, lower digit |
| vref_mv | input | MVW | Reference value in millivolts |
| uv_flag | output | NCELL+NTEMP | Per-channel undervoltage flags |
| ov_flag | output | NCELL | Per-cell overvoltage flags |
| stack_good | output | 1 | Stack healthy, refreshed per pass |

## Verification
Readings are placed one millivolt on either side of the trip point and exactly on it for several select combinations, including the 2'b11 code. This separates the strict comparisons and the index decode from off-by-one faults. Readings at the edge of each hysteresis band and one millivolt past it show whether a set flag holds or clears. The same pattern at the lowest UV setting and on a temperature channel shows whether the band is suppressed there. Full measurement passes with a fault on a cell above and below the configured count, and on a temperature channel, separate the masking from the end-of-pass timing of stack_good.

// File: rtl/cell_fault_comparator.sv
module cell_fault_comparator #(
  parameter int NCELL = 12,
  parameter int NTEMP = 2,
  parameter int MVW   = 13,
  parameter int CHW   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_valid,
  input  logic [CHW-1:0]         rd_chan,
  input  logic [MVW-1:0]         rd_mv,
  input  logic [1:0]             ov_hi_sel,
  input  logic [1:0]             ov_lo_sel,
  input  logic [1:0]             uv_hi_sel,
  input  logic [1:0]             uv_lo_sel,
  input  logic [1:0]             hyst_sel,
  input  logic [1:0]             cc_hi_sel,
  input  logic [1:0]             cc_lo_sel,
  input  logic [MVW-1:0]         vref_mv,
  output logic [NCELL+NTEMP-1:0] uv_flag,
  output logic [NCELL-1:0]       ov_flag,
  output logic                   stack_good
);
  localparam int NCH  = NCELL + NTEMP;
  localparam int LAST = NCH - 1;
  localparam int TW   = MVW + 1;

  function automatic int digit(input logic [1:0] code);
    case (code)
      2'b01:   return 1;
      2'b00:   return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [3:0] tidx(input logic [1:0] hi, input logic [1:0] lo);
    return 4'(3 * digit(hi) + digit(lo));
  endfunction

  function automatic logic [TW-1:0] ov_table(input logic [3:0] i);
    case (i)
      4'd0:    return TW'(4498);
      4'd1:    return TW'(4403);
      4'd2:    return TW'(4307);
      4'd3:    return TW'(4211);
      4'd4:    return TW'(4116);
      4'd5:    return TW'(4020);
      4'd6:    return TW'(3924);
      4'd7:    return TW'(3828);
      default: return TW'(3733);
    endcase
  endfunction

  function automatic logic [TW-1:0] uv_table(input logic [3:0] i);
    case (i)
      4'd0:    return TW'(2871);
      4'd1:    return TW'(2680);
      4'd2:    return TW'(2489);
      4'd3:    return TW'(2297);
      4'd4:    return TW'(2106);
      4'd5:    return TW'(1914);
      4'd6:    return TW'(1723);
      4'd7:    return TW'(1531);
      default: return TW'(766);
    endcase
  endfunction

  logic [3:0]    ov_idx, uv_idx, cc_idx;
  logic [TW-1:0] ov_thr, uv_thr, tmp_thr, ov_band, uv_band, rd_ext;
  logic [NCELL-1:0] cell_mask, ov_nx;
  logic [NCH-1:0]   uv_nx;
  int               cell_cnt;

  assign ov_idx  = tidx(ov_hi_sel, ov_lo_sel);
  assign uv_idx  = tidx(uv_hi_sel, uv_lo_sel);
  assign cc_idx  = tidx(cc_hi_sel, cc_lo_sel);
  assign ov_thr  = ov_table(ov_idx);
  assign uv_thr  = uv_table(uv_idx);
  assign tmp_thr = TW'(vref_mv >> 1);
  assign rd_ext  = TW'(rd_mv);
  assign cell_cnt = 12 - int'(cc_idx);

  always_comb begin
    case (digit(hyst_sel))
      0:       begin uv_band = TW'(500); ov_band = TW'(200); end
      1:       begin uv_band = TW'(250); ov_band = TW'(100); end
      default: begin uv_band = '0;       ov_band = '0;       end
    endcase
    if (uv_idx == 4'd8) uv_band = '0;
  end

  always_comb begin
    for (int c = 0; c < NCELL; c++) cell_mask[c] = (c < cell_cnt);
  end

  always_comb begin
    uv_nx = uv_flag;
    ov_nx = ov_flag;
    if (rd_valid) begin
      for (int c = 0; c < NCH; c++) begin
        if (rd_chan == CHW'(c)) begin
          if (c < NCELL) begin
            uv_nx[c] = uv_flag[c] ? (rd_ext <= uv_thr + uv_band) : (rd_ext < uv_thr);
            ov_nx[c] = ov_flag[c] ? (rd_ext >= ov_thr - ov_band) : (rd_ext > ov_thr);
          end else begin
            uv_nx[c] = rd_ext < tmp_thr;
          end
        end
      end
    end
  end

  wire pass_end = rd_valid && (rd_chan == CHW'(LAST));
  wire any_fault = |(uv_nx & {{NTEMP{1'b1}}, cell_mask}) || |(ov_nx & cell_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_flag    <= '0;
      ov_flag    <= '0;
      stack_good <= 1'b1;
    end else begin
      uv_flag <= uv_nx;
      ov_flag <= ov_nx;
      if (pass_end) stack_good <= !any_fault;
    end
  end
endmodule

// File: rtl/cell_fault_checker.sv
module cell_fault_checker #(
  parameter int NCELL = 12,
  parameter int NTEMP = 2,
  parameter int CHW   = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rd_valid,
  input logic [CHW-1:0]         rd_chan,
  input logic [NCELL+NTEMP-1:0] uv_flag,
  input logic [NCELL-1:0]       ov_flag,
  input logic                   stack_good
);
  localparam int NCH = NCELL + NTEMP;

  a_r9_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> ($stable(uv_flag) && $stable(ov_flag)));

  a_r9_bad_index_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && (int'(rd_chan) >= NCH)) |=> ($stable(uv_flag) && $stable(ov_flag)));

  a_r9_one_channel_moves: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(uv_flag ^ $past(uv_flag)) <= 1) && ($countones(ov_flag ^ $past(ov_flag)) <= 1));

  a_r8_good_only_at_pass_end: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && (int'(rd_chan) == NCH - 1)) |=> $stable(stack_good));

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_flag[NCELL-1:0] & ov_flag) == '0);
endmodule

bind cell_fault_comparator cell_fault_checker #(.NCELL(NCELL), .NTEMP(NTEMP), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_chan(rd_chan),
  .uv_flag(uv_flag), .ov_flag(ov_flag), .stack_good(stack_good));

// File: tb/sim_cell_fault_comparator.sv
module sim_cell_fault_comparator;
  localparam int CLK_PERIOD = 10;
  localparam int NCELL = 12, NTEMP = 2, MVW = 13, CHW = 4;
  localparam int NCH = NCELL + NTEMP;

  logic clk = 0, rst_n = 0, rd_valid = 0;
  logic [CHW-1:0] rd_chan = '0;
  logic [MVW-1:0] rd_mv = '0, vref_mv = 13'd3058;
  logic [1:0] ov_hi_sel = 2'b10, ov_lo_sel = 2'b10, uv_hi_sel = 2'b10, uv_lo_sel = 2'b10;
  logic [1:0] hyst_sel = 2'b00, cc_hi_sel = 2'b10, cc_lo_sel = 2'b10;
  logic [NCH-1:0] uv_flag;
  logic [NCELL-1:0] ov_flag;
  logic stack_good;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cell_fault_comparator #(.NCELL(NCELL), .NTEMP(NTEMP), .MVW(MVW), .CHW(CHW)) u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input int ch, input int mv);
    @(negedge clk);
    rd_valid = 1; rd_chan = CHW'(ch); rd_mv = MVW'(mv);
    @(negedge clk);
    rd_valid = 0;
  endtask

  task automatic t_reset;
    check("R10 uv after reset", 32'(uv_flag), 0);
    check("R10 ov after reset", 32'(ov_flag), 0);
    check("R10 stack_good after reset", 32'(stack_good), 1);
  endtask

  task automatic t_ov_select;
    hyst_sel = 2'b00; ov_hi_sel = 2'b10; ov_lo_sel = 2'b10;
    send(0, 4498); check("R2 ov at threshold 4498", 32'(ov_flag[0]), 0);
    send(0, 4499); check("R2 ov above 4498", 32'(ov_flag[0]), 1);
    send(0, 4497); check("R4 ov clears zero band", 32'(ov_flag[0]), 0);
    ov_hi_sel = 2'b01; ov_lo_sel = 2'b00;
    send(1, 4020); check("R1 ov index5 at 4020", 32'(ov_flag[1]), 0);
    send(1, 4021); check("R1 ov index5 above 4020", 32'(ov_flag[1]), 1);
    ov_hi_sel = 2'b11; ov_lo_sel = 2'b11;
    send(1, 4400); check("R1 code 11 reads as high, 4400 clears", 32'(ov_flag[1]), 0);
    ov_hi_sel = 2'b10; ov_lo_sel = 2'b10;
  endtask

  task automatic t_uv_select;
    uv_hi_sel = 2'b00; uv_lo_sel = 2'b01;
    send(2, 1530); check("R3 uv index7 below 1531", 32'(uv_flag[2]), 1);
    send(2, 1532); check("R3 uv index7 clears", 32'(uv_flag[2]), 0);
    send(2, 1531); check("R3 uv index7 at threshold", 32'(uv_flag[2]), 0);
    uv_hi_sel = 2'b10; uv_lo_sel = 2'b10;
    send(2, 2870); check("R3 uv index0 below 2871", 32'(uv_flag[2]), 1);
    send(2, 3000); check("R3 uv index0 clears", 32'(uv_flag[2]), 0);
  endtask

  task automatic t_hyst;
    hyst_sel = 2'b10;
    send(3, 2870); check("R4 uv sets", 32'(uv_flag[3]), 1);
    send(3, 3371); check("R4 uv holds at thr+500", 32'(uv_flag[3]), 1);
    send(3, 3372); check("R4 uv clears past thr+500", 32'(uv_flag[3]), 0);
    hyst_sel = 2'b01;
    send(4, 4499); check("R4 ov sets", 32'(ov_flag[4]), 1);
    send(4, 4398); check("R4 ov holds at thr-100", 32'(ov_flag[4]), 1);
    send(4, 4397); check("R4 ov clears past thr-100", 32'(ov_flag[4]), 0);
    send(4, 3000); check("R11 uv and ov exclusive on cell", 32'(uv_flag[4] & ov_flag[4]), 0);
  endtask

  task automatic t_uv_lowest;
    hyst_sel = 2'b10; uv_hi_sel = 2'b00; uv_lo_sel = 2'b00;
    send(5, 765); check("R5 uv sets below 766", 32'(uv_flag[5]), 1);
    send(5, 766); check("R5 uv holds at 766", 32'(uv_flag[5]), 1);
    send(5, 767); check("R5 uv clears with band forced off", 32'(uv_flag[5]), 0);
    uv_hi_sel = 2'b10; uv_lo_sel = 2'b10;
  endtask

  task automatic t_temp;
    hyst_sel = 2'b10; vref_mv = 13'd3058;
    send(12, 1528); check("R6 temp uv below 1529", 32'(uv_flag[12]), 1);
    send(12, 1531); check("R6 temp uv clears, no band", 32'(uv_flag[12]), 0);
    send(13, 5000); check("R6 temp has no ov", 32'({uv_flag[13], ov_flag}), 0);
    hyst_sel = 2'b00;
  endtask

  task automatic t_bad_index;
    logic [NCH-1:0] uv_s; logic [NCELL-1:0] ov_s;
    send(6, 100);
    uv_s = uv_flag; ov_s = ov_flag;
    send(15, 6000); send(14, 0);
    check("R9 bad index uv unchanged", 32'(uv_flag), 32'(uv_s));
    check("R9 bad index ov unchanged", 32'(ov_flag), 32'(ov_s));
    send(6, 3600); check("R9 own channel updates", 32'(uv_flag[6]), 0);
  endtask

  task automatic t_stack;
    hyst_sel = 2'b00; cc_hi_sel = 2'b10; cc_lo_sel = 2'b10;
    for (int c = 0; c < NCELL; c++) send(c, 3600);
    send(12, 2000); send(13, 2000);
    check("R8 clean pass gives good", 32'(stack_good), 1);
    cc_hi_sel = 2'b00; cc_lo_sel = 2'b00;
    send(7, 1000); check("R8 no change mid pass", 32'(stack_good), 1);
    send(13, 2000); check("R7 cell 7 masked at count 4", 32'(stack_good), 1);
    cc_hi_sel = 2'b10; cc_lo_sel = 2'b10;
    check("R8 count change alone no effect", 32'(stack_good), 1);
    send(13, 2000); check("R7 cell 7 counted at count 12", 32'(stack_good), 0);
    send(7, 3600); check("R8 clear mid pass holds bad", 32'(stack_good), 0);
    send(13, 2000); check("R8 recovers at pass end", 32'(stack_good), 1);
    cc_hi_sel = 2'b00; cc_lo_sel = 2'b00;
    send(12, 1000); send(13, 2000);
    check("R7 temp fault never masked", 32'(stack_good), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ov_select();
    t_uv_select();
    t_hyst();
    t_uv_lowest();
    t_temp();
    t_bad_index();
    t_stack();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule